// File: doc/BRIEF.md
# Autonomous Thread Sequencer

This controller walks a reconfigurable array through a programmed chain of threads, each thread standing for one array configuration. A small table holds one entry per thread. An entry either names one fixed successor, or names two candidates and a trigger line. In the second case the successor is chosen at run time by that trigger line, which the array derives from its own results, such as ALU flags.

An outside processor programs the table while the sequencer is idle, then kicks a start thread. From then on the sequencer runs without processor involvement. Each time the active thread reports completion, it looks up the successor, makes that successor current and pulses a switch request for one cycle so that the configuration loader can act. Completion of an entry marked as final returns the sequencer to idle and raises a sticky interrupt. A jump to a table slot that was never programmed raises a sticky error and halts the sequencer.

Top module: `thr_seq`

## Requirements
- R1: After reset, busy_o, switch_req_o, irq_o and err_o are 0, cur_thread_o is 0, and every table slot is unprogrammed.
- R2: With the sequencer idle and err_o low, kick_i makes slot start_idx_i current if that slot is programmed. One cycle later busy_o is 1, cur_thread_o equals start_idx_i and switch_req_o is high for that one cycle. kick_i has no effect while busy_o or err_o is high.
- R3: An entry with its branch bit (bit 12) clear moves, on done_i, to the index in its true field (bits 7:4). cur_thread_o shows the new index and switch_req_o is high for one cycle, both in the cycle after done_i.
- R4: An entry with its branch bit set moves, on done_i, to the true field (bits 7:4) when trig_i[sel] is 1, and to the false field (bits 3:0) when it is 0. Here sel is bits 10:8 of the entry, and the other trig_i bits have no influence.
- R5: On done_i, an entry with its final bit (bit 11) set returns the sequencer to idle with no switch request and sets irq_o. irq_o stays high until irq_clr_i is pulsed.
- R6: When the start slot or the successor slot is unprogrammed, err_o is set, the sequencer goes idle, no switch request is issued and cur_thread_o keeps its value. err_o stays high until err_clr_i is pulsed.
- R7: A table write, which sets tbl_data_i into slot tbl_addr_i and marks the slot programmed, takes effect only while the sequencer is idle. A write while busy leaves the table unchanged.
- R8: done_i while idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 4 | Table slot to write |
| tbl_data_i | input | 13 | Entry: [12] branch, [11] final, [10:8] trigger select, [7:4] true index, [3:0] false index |
| kick_i | input | 1 | Start request from the processor |
| start_idx_i | input | 4 | First thread to run |
| done_i | input | 1 | Active thread has finished |
| trig_i | input | 8 | Trigger conditions from the array |
| irq_clr_i | input | 1 | Clears irq_o |
| err_clr_i | input | 1 | Clears err_o |
| busy_o | output | 1 | Sequence running |
| cur_thread_o | output | 4 | Current (last) thread index |
| switch_req_o | output | 1 | One-cycle configuration switch request |
| irq_o | output | 1 | Sequence completed |
| err_o | output | 1 | Invalid jump detected |

## Verification
Every decision of the sequencer appears at the ports in the cycle after done_i or kick_i. A wrong successor choice therefore shows at once as a wrong cur_thread_o, and a wrong mode decision shows as a missing or extra switch_req_o pulse or as an unexpected busy_o level. A corrupted table entry or a wrongly applied write may stay hidden until that slot is reached. For this reason the bench drives full sequences through both branch outcomes, and it checks the write lock by running through the slot it tried to overwrite.

// File: rtl/thr_seq_pkg.sv
package thr_seq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/thr_seq_tbl.sv
module thr_seq_tbl #(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned ENT_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             lock_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [ENT_W-1:0] rdata_o,
  input  logic [IDX_W-1:0] chk_idx_i,
  output logic             chk_valid_o
);
  logic [ENT_W-1:0]   mem_q [N_ENTRY];
  logic [N_ENTRY-1:0] valid_q;
  logic [N_ENTRY-1:0] wen;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_wen
    assign wen[g] = we_i && !lock_i && (waddr_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N_ENTRY; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENTRY; i++) begin
        if (wen[i]) begin
          mem_q[i]   <= wdata_i;
          valid_q[i] <= 1'b1;
        end
      end
    end
  end

  assign rdata_o     = mem_q[raddr_i];
  assign chk_valid_o = valid_q[chk_idx_i];

  // R7: table frozen while running
  a_r7_lock_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(valid_q));
  a_r7_lock_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && we_i) |=> mem_q[$past(waddr_i)] == $past(mem_q[waddr_i]));
endmodule

// File: rtl/thr_seq_nxt.sv
module thr_seq_nxt #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned ENT_W  = 13
) (
  input  logic [ENT_W-1:0]  entry_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic [IDX_W-1:0]  nxt_idx_o,
  output logic              last_o
);
  logic             is_branch;
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx_t, idx_f;

  assign is_branch = entry_i[ENT_W-1];
  assign last_o    = entry_i[ENT_W-2];
  assign sel       = entry_i[ENT_W-3 -: SEL_W];
  assign idx_t     = entry_i[2*IDX_W-1 -: IDX_W];
  assign idx_f     = entry_i[IDX_W-1:0];

  always_comb begin
    nxt_idx_o = idx_t;
    if (is_branch && !trig_i[sel]) nxt_idx_o = idx_f;
  end
endmodule

// File: rtl/thr_seq_ctrl.sv
module thr_seq_ctrl
  import thr_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kick_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             done_i,
  input  logic             irq_clr_i,
  input  logic             err_clr_i,
  input  logic [IDX_W-1:0] nxt_idx_i,
  input  logic             last_i,
  input  logic             cand_valid_i,
  output logic [IDX_W-1:0] chk_idx_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] cur_o,
  output logic             req_o,
  output logic             irq_o,
  output logic             err_o
);
  seq_state_e       st_q;
  logic [IDX_W-1:0] cur_q;
  logic             req_q, irq_q, err_q;

  assign chk_idx_o = (st_q == ST_IDLE) ? start_idx_i : nxt_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      req_q <= 1'b0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (irq_clr_i) irq_q <= 1'b0;
      if (err_clr_i) err_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (kick_i && !err_q) begin
            if (cand_valid_i) begin
              st_q  <= ST_RUN;
              cur_q <= start_idx_i;
              req_q <= 1'b1;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (done_i) begin
            if (last_i) begin
              st_q  <= ST_IDLE;
              irq_q <= 1'b1;
            end else if (cand_valid_i) begin
              cur_q <= nxt_idx_i;
              req_q <= 1'b1;
            end else begin
              st_q  <= ST_IDLE;
              err_q <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_RUN);
  assign cur_o  = cur_q;
  assign req_o  = req_q;
  assign irq_o  = irq_q;
  assign err_o  = err_q;

  // R2: request only while running
  a_r2_req_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> st_q == ST_RUN);
  // R2: kick ignored while running without completion
  a_r2_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !done_i) |=> $stable(cur_q) && !req_q);
  // R5: completion interrupt leaves sequencer idle
  a_r5_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> st_q == ST_IDLE && !req_q);
  // R6: error halts
  a_r6_err_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> st_q == ST_IDLE && !req_q && $stable(cur_q));
  // R8: idle without kick stays idle
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !kick_i) |=> st_q == ST_IDLE && !req_q);
endmodule

// File: rtl/thr_seq.sv
module thr_seq #(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned N_TRIG  = 8,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY),
  localparam int unsigned SEL_W  = $clog2(N_TRIG),
  localparam int unsigned ENT_W  = 2 + SEL_W + 2*IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [ENT_W-1:0]  tbl_data_i,
  input  logic              kick_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic              done_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              irq_clr_i,
  input  logic              err_clr_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  cur_thread_o,
  output logic              switch_req_o,
  output logic              irq_o,
  output logic              err_o
);
  logic [ENT_W-1:0] cur_entry;
  logic [IDX_W-1:0] nxt_idx, chk_idx, cur_idx;
  logic             last, cand_valid, busy;

  thr_seq_tbl #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .lock_i     (busy),
    .waddr_i    (tbl_addr_i),
    .wdata_i    (tbl_data_i),
    .raddr_i    (cur_idx),
    .rdata_o    (cur_entry),
    .chk_idx_i  (chk_idx),
    .chk_valid_o(cand_valid)
  );

  thr_seq_nxt #(.IDX_W(IDX_W), .SEL_W(SEL_W), .N_TRIG(N_TRIG), .ENT_W(ENT_W)) u_nxt (
    .entry_i  (cur_entry),
    .trig_i   (trig_i),
    .nxt_idx_o(nxt_idx),
    .last_o   (last)
  );

  thr_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kick_i      (kick_i),
    .start_idx_i (start_idx_i),
    .done_i      (done_i),
    .irq_clr_i   (irq_clr_i),
    .err_clr_i   (err_clr_i),
    .nxt_idx_i   (nxt_idx),
    .last_i      (last),
    .cand_valid_i(cand_valid),
    .chk_idx_o   (chk_idx),
    .busy_o      (busy),
    .cur_o       (cur_idx),
    .req_o       (switch_req_o),
    .irq_o       (irq_o),
    .err_o       (err_o)
  );

  assign busy_o       = busy;
  assign cur_thread_o = cur_idx;
endmodule

// File: tb/thr_seq_test.sv
module thr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [12:0] wdata = '0;
  logic        kick = 1'b0;
  logic [3:0]  start = '0;
  logic        done = 1'b0;
  logic [7:0]  trig = '0;
  logic        iclr = 1'b0;
  logic        eclr = 1'b0;
  logic        busy, req, irq, err;
  logic [3:0]  cur;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thr_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(we), .tbl_addr_i(waddr), .tbl_data_i(wdata),
    .kick_i(kick), .start_idx_i(start), .done_i(done), .trig_i(trig),
    .irq_clr_i(iclr), .err_clr_i(eclr), .busy_o(busy), .cur_thread_o(cur),
    .switch_req_o(req), .irq_o(irq), .err_o(err)
  );

  // in: kick, start[3:0], done, trig[7:0], irq_clr | out: busy, cur[3:0], req, irq, err
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,4'd0,1'b0,8'h00,1'b0, 1'b1,4'd0,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b0,8'h00,1'b0, 1'b1,4'd0,1'b0,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'h04,1'b0, 1'b1,4'd1,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'h04,1'b0, 1'b1,4'd3,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b0,8'h00,1'b0, 1'b1,4'd3,1'b0,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'h04,1'b0, 1'b1,4'd4,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'h00,1'b0, 1'b0,4'd4,1'b0,1'b1,1'b0},
    {1'b0,4'd0,1'b0,8'h00,1'b1, 1'b0,4'd4,1'b0,1'b0,1'b0},
    {1'b1,4'd0,1'b0,8'h00,1'b0, 1'b1,4'd0,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'hFB,1'b0, 1'b1,4'd1,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'hFB,1'b0, 1'b1,4'd2,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'hFB,1'b0, 1'b1,4'd4,1'b1,1'b0,1'b0},
    {1'b0,4'd0,1'b1,8'h00,1'b0, 1'b0,4'd4,1'b0,1'b1,1'b0},
    {1'b0,4'd0,1'b0,8'h00,1'b1, 1'b0,4'd4,1'b0,1'b0,1'b0}
  };

  function automatic logic [7:0] outs();
    return {busy, cur, req, irq, err};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: got busy/cur/req/irq/err=%b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic cyc(input logic k, input logic [3:0] s, input logic d, input logic [7:0] t,
                     input logic ic, input logic ec);
    @(negedge clk);
    kick = k; start = s; done = d; trig = t; iclr = ic; eclr = ec; we = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic br, input logic fin, input logic [2:0] sel,
                    input logic [3:0] nt, input logic [3:0] nf);
    @(negedge clk);
    kick = 1'b0; done = 1'b0; iclr = 1'b0; eclr = 1'b0;
    we = 1'b1; waddr = a; wdata = {br, fin, sel, nt, nf};
    @(posedge clk);
    #1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 8'b0_0000_0_0_0);
    rst_n = 1'b1;
    // R8: done while idle
    cyc(1'b0, 4'd0, 1'b1, 8'hFF, 1'b0, 1'b0);
    check("R8 idle done", 8'b0_0000_0_0_0);
    // R6: start slot unprogrammed
    cyc(1'b1, 4'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R6 unprogrammed start", 8'b0_0000_0_0_1);
    cyc(1'b0, 4'd0, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R6 err clear", 8'b0_0000_0_0_0);

    wr(4'd0, 1'b0, 1'b0, 3'd0, 4'd1, 4'd0);
    wr(4'd1, 1'b1, 1'b0, 3'd2, 4'd3, 4'd2);
    wr(4'd2, 1'b0, 1'b0, 3'd0, 4'd4, 4'd0);
    wr(4'd3, 1'b0, 1'b0, 3'd0, 4'd4, 4'd0);
    wr(4'd4, 1'b0, 1'b1, 3'd0, 4'd0, 4'd0);
    wr(4'd5, 1'b0, 1'b0, 3'd0, 4'd9, 4'd0);

    // R2 R3 R4 R5: table-driven sequences, both branch outcomes
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][22], VEC[i][21:18], VEC[i][17], VEC[i][16:9], VEC[i][8], 1'b0);
      check($sformatf("R2 R3 R4 R5 vector %0d", i), VEC[i][7:0]);
    end

    // R6: jump to unprogrammed slot 9
    cyc(1'b1, 4'd5, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R2 start slot 5", 8'b1_0101_1_0_0);
    cyc(1'b0, 4'd0, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R6 invalid jump", 8'b0_0101_0_0_1);
    // R2: kick ignored while err set
    cyc(1'b1, 4'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R2 kick blocked by err", 8'b0_0101_0_0_1);
    cyc(1'b0, 4'd0, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R6 err clear", 8'b0_0101_0_0_0);

    // R2: kick ignored while busy
    cyc(1'b1, 4'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R2 start slot 0", 8'b1_0000_1_0_0);
    cyc(1'b1, 4'd2, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R2 kick while busy", 8'b1_0000_0_0_0);
    // R7: write while busy must not change slot 1
    wr(4'd1, 1'b0, 1'b1, 3'd0, 4'd0, 4'd0);
    cyc(1'b0, 4'd0, 1'b1, 8'h04, 1'b0, 1'b0);
    check("R7 locked write step", 8'b1_0001_1_0_0);
    cyc(1'b0, 4'd0, 1'b1, 8'h04, 1'b0, 1'b0);
    check("R7 slot 1 still branches", 8'b1_0011_1_0_0);
    cyc(1'b0, 4'd0, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R7 to slot 4", 8'b1_0100_1_0_0);
    cyc(1'b0, 4'd0, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R5 final slot", 8'b0_0100_0_1_0);
    // R5: irq held until cleared
    cyc(1'b0, 4'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R5 irq sticky", 8'b0_0100_0_1_0);
    cyc(1'b0, 4'd0, 1'b0, 8'h00, 1'b1, 1'b0);
    check("R5 irq clear", 8'b0_0100_0_0_0);

    // R7: write while idle takes effect
    wr(4'd6, 1'b0, 1'b1, 3'd0, 4'd0, 4'd0);
    cyc(1'b1, 4'd6, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R7 idle write start", 8'b1_0110_1_0_0);
    cyc(1'b0, 4'd0, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R7 idle write final", 8'b0_0110_0_1_0);

    finish_run();
  end
endmodule